// File: doc/BRIEF.md
# Counted-Frame Serial Word Receiver

This block takes a 16-bit command word from a three-wire host link. The link has an active-low select, a serial clock and one data line. All three lines are sampled in a much faster system-clock domain, and each goes through a two-flop synchronizer. Edges are found by comparing each synchronized sample with the one before it. Bits enter a shift register most-significant first, on falling serial-clock edges, while select is low. A counter tracks how many bits have arrived in the current frame.

When the frame is complete, the block raises a one-cycle commit strobe and presents the captured word. The commit follows whichever of these comes first after the sixteenth falling edge: the next rising serial-clock edge, or the release of select. After the commit, the receiver locks out further bits until select goes high and then falls again. A frame that ends before sixteen bits is dropped without a strobe. A downstream decoder reads bits 15..12 as program bits and bits 11..0 as a 12-bit value. That decoding is not part of this block.

The control FSM has four states:
- IDLE waits for select to fall. Transition *start* goes to SHIFT and clears the counter.
- SHIFT takes bits. Transition *abort* returns to IDLE when select rises. Transition *filled* goes to FULL on the sixteenth falling edge.
- FULL holds a complete word. Transition *clock_commit* goes to LOCKED on a rising serial-clock edge. Transition *select_commit* goes to IDLE when select rises.
- LOCKED ignores all bits. Transition *release* returns to IDLE when select rises.

Top module: `serial_word_rx`

## Requirements
- R1: After synchronous reset, `commit_o` is 0 and `word_o` is 0x0000.
- R2: While select is low in a frame, each falling serial-clock edge shifts one data bit in. The first bit of the frame ends up in `word_o[15]` and the sixteenth in `word_o[0]`.
- R3: After the sixteenth falling edge, the next rising serial-clock edge produces a commit. `commit_o` is high for exactly one system-clock cycle.
- R4: If select rises after the sixteenth falling edge and before any rising serial-clock edge, the commit occurs on the select rise with the same word.
- R5: Each frame gives at most one commit. Extra bits after the commit in the same frame do not change `word_o` and produce no further strobe.
- R6: A frame in which select rises before sixteen bits have arrived produces no commit, and `word_o` keeps its previous value.
- R7: Serial-clock and data activity while select is high has no effect on the next frame's captured word.
- R8: A frame begins only on a falling edge of select, and that edge re-arms the bit counter to zero.
- R9: `word_o` changes only in a cycle where `commit_o` is high, and holds the last committed word otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n_in | input | 1 | Asynchronous frame select, active low |
| sck_in | input | 1 | Asynchronous serial clock |
| sdi_in | input | 1 | Asynchronous serial data |
| commit_o | output | 1 | One-cycle strobe when a word is committed |
| word_o | output | 16 | Last committed word |

## Verification
On every cycle, the assertions check the following:
- The strobe is one cycle wide.
- The output word is stable outside commits.
- The shift register is frozen while select is high or after lockout.
- The bit counter never exceeds the word length.
- An aborted frame never yields a strobe.

Only the bench scenarios can show the rest:
- MSB-first bit ordering.
- Which of the two commit triggers fired.
- Discarding of short frames.
- Immunity to clocking while deselected.
- The exact words committed.

// File: rtl/swr_pkg.sv
package swr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_FULL   = 2'd2,
        ST_LOCKED = 2'd3
    } frame_state_t;
endpackage

// File: rtl/swr_sync.sv
module swr_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0] chain [W];

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                chain[b] <= {STAGES{RST_VAL[b]}};
            end else begin
                chain[b] <= {chain[b][STAGES-2:0], d[b]};
            end
        end
        assign q[b] = chain[b][STAGES-1];
    end
endmodule

// File: rtl/swr_edge.sv
module swr_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= RST_VAL;
        else     prev <= lvl;
    end

    assign rise = lvl & ~prev;
    assign fall = ~lvl & prev;
endmodule

// File: rtl/swr_frame_ctl.sv
module swr_frame_ctl
    import swr_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_hi,
    input  logic              sel_rise,
    input  logic              sel_fall,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              sdi,
    output logic              commit_o,
    output logic [WORD_W-1:0] word_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    frame_state_t      state, state_nx;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] shreg;
    logic              take_bit;
    logic              fire;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // transitions: start, abort, filled, clock_commit, select_commit, release
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (sel_fall) state_nx = ST_SHIFT;
            ST_SHIFT: begin
                if (sel_rise)                            state_nx = ST_IDLE;
                else if (sck_fall && bit_cnt == LAST_BIT) state_nx = ST_FULL;
            end
            ST_FULL: begin
                if (sel_rise)      state_nx = ST_IDLE;
                else if (sck_rise) state_nx = ST_LOCKED;
            end
            ST_LOCKED: if (sel_rise) state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    assign take_bit = (state == ST_SHIFT) && sck_fall && !sel_rise;
    assign fire     = (state == ST_FULL) && (sel_rise || sck_rise);

    // shift register and bit counter
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (state == ST_IDLE && sel_fall) begin
            bit_cnt <= '0;
        end else if (take_bit) begin
            shreg   <= {shreg[WORD_W-2:0], sdi};
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            commit_o <= 1'b0;
            word_o   <= '0;
        end else begin
            commit_o <= fire;
            if (fire) word_o <= shreg;
        end
    end

    a_r7_no_shift_deselected: assert property (@(posedge clk) disable iff (rst)
        sel_hi |=> $stable(shreg));
    a_r5_locked_frozen: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOCKED) |=> $stable(shreg));
    a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_W'(WORD_W));
    a_r6_abort_silent: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT && sel_rise) |=> !commit_o);
    a_r4_select_commit: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FULL && sel_rise) |=> commit_o);
endmodule

// File: rtl/serial_word_rx.sv
module serial_word_rx #(
    parameter int WORD_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n_in,
    input  logic              sck_in,
    input  logic              sdi_in,
    output logic              commit_o,
    output logic [WORD_W-1:0] word_o
);
    logic [2:0] raw, synced;
    logic       sel_s, sck_s, sdi_s;
    logic       sel_rise, sel_fall, sck_rise, sck_fall;

    assign raw = {sel_n_in, sck_in, sdi_in};

    swr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(synced)
    );
    assign {sel_s, sck_s, sdi_s} = synced;

    swr_edge #(.RST_VAL(1'b1)) u_sel_edge (
        .clk(clk), .rst(rst), .lvl(sel_s), .rise(sel_rise), .fall(sel_fall)
    );
    swr_edge #(.RST_VAL(1'b1)) u_sck_edge (
        .clk(clk), .rst(rst), .lvl(sck_s), .rise(sck_rise), .fall(sck_fall)
    );

    swr_frame_ctl #(.WORD_W(WORD_W)) u_ctl (
        .clk(clk), .rst(rst),
        .sel_hi(sel_s), .sel_rise(sel_rise), .sel_fall(sel_fall),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi(sdi_s),
        .commit_o(commit_o), .word_o(word_o)
    );

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        commit_o |=> !commit_o);
    a_r9_word_stable: assert property (@(posedge clk) disable iff (rst)
        !commit_o |-> $stable(word_o));
endmodule

// File: tb/serial_word_rx_tb_top.sv
module serial_word_rx_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1;
    logic        sck = 1'b1;
    logic        sdi = 1'b0;
    logic        commit;
    logic [15:0] word;

    int          n_checks = 0;
    int          n_fails  = 0;
    bit          done     = 1'b0;
    logic [15:0] exp_q [$];
    logic [15:0] last_word = 16'h0000;

    always #10 clk = ~clk;

    serial_word_rx dut_i (
        .clk(clk), .rst(rst), .sel_n_in(sel_n), .sck_in(sck), .sdi_in(sdi),
        .commit_o(commit), .word_o(word)
    );

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pop expected words as commits appear
    always @(negedge clk) begin
        if (!rst && commit) begin
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fails++;
                $display("FAIL R5 actual=unexpected commit %h expected=no commit", word);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                if (word !== e) begin
                    n_fails++;
                    $display("FAIL R2 actual=%h expected=%h", word, e);
                end
                last_word = e;
            end
        end
    end

    task automatic one_bit(input logic b, input bit stop_low);
        sdi = b;
        wait_clk(4);
        sck = 1'b0;
        wait_clk(4);
        if (!stop_low) begin
            sck = 1'b1;
            wait_clk(4);
        end
    endtask

    task automatic send_bits(input logic [31:0] bits, input int n, input bit stop_low);
        for (int i = n - 1; i >= 0; i--) one_bit(bits[i], stop_low && i == 0);
    endtask

    task automatic sel_low();  sel_n = 1'b0; wait_clk(4); endtask
    task automatic sel_high(); sel_n = 1'b1; wait_clk(4); endtask

    task automatic drain(input string req);
        wait_clk(10);
        check(req, 16'(exp_q.size()), 16'd0);
    endtask

    task automatic full_frame(input logic [15:0] w);
        exp_q.push_back(w);
        sel_low();
        send_bits({16'h0, w}, 16, 1'b0);
        sel_high();
        drain("R3");
    endtask

    initial begin
        wait_clk(5);
        // R1 reset state
        check("R1", {15'h0, commit}, 16'h0);
        check("R1", word, 16'h0000);
        rst = 1'b0;
        wait_clk(6);

        // R3 commit on rising clock after 16th bit; R2 ordering
        full_frame(16'h8001);
        check("R2", word, 16'h8001);
        full_frame(16'hA5C3);
        full_frame(16'h0FFF);

        // R4 select rises while clock low after 16th fall
        exp_q.push_back(16'h5A96);
        sel_low();
        send_bits({16'h0, 16'h5A96}, 16, 1'b1);
        sel_high();
        sck = 1'b1;
        wait_clk(4);
        drain("R4");
        check("R4", word, 16'h5A96);

        // R5 long frame: extra bits ignored, single commit
        exp_q.push_back(16'h1234);
        sel_low();
        send_bits({16'h1234, 16'hFFFF}, 32, 1'b0);
        check("R5", word, 16'h1234);
        sel_high();
        drain("R5");

        // R6 short frame discarded
        sel_low();
        send_bits(32'h3FF, 10, 1'b0);
        sel_high();
        drain("R6");
        check("R6", word, 16'h1234);
        // R6 fifteen bits, still discarded
        sel_low();
        send_bits(32'h7FFF, 15, 1'b0);
        sel_high();
        drain("R6");
        check("R6", word, 16'h1234);

        // R7 activity with select high
        send_bits(32'hFFFF_FFFF, 20, 1'b0);
        wait_clk(10);
        check("R7", word, 16'h1234);
        full_frame(16'h00F0);

        // R8 counter re-armed after abort: short then full frame
        sel_low();
        send_bits(32'h5, 3, 1'b0);
        sel_high();
        full_frame(16'hC003);
        check("R8", word, 16'hC003);

        // R9 several frames back to back
        for (int k = 0; k < 6; k++) full_frame(16'(16'h1357 * (k + 3)));
        check("R9", word, last_word);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule